// File: doc/BRIEF.md
# PHY Management Read Master

This block runs register reads over the two-wire serial management bus of an Ethernet PHY. A one-cycle `start_i` pulse carries a 5-bit PHY address and a 5-bit register address. The block then makes the management clock by dividing the system clock. On the data line it sends an all-ones preamble, the start and read-opcode codes and the two addresses. After that it releases the line for turnaround, shifts in sixteen data bits and ends with two released idle clocks. The read value appears on `rdata_o` in the same cycle as a single-cycle `done_o` pulse.

The data line is bidirectional. The block drives it through `mdio_o` and `mdio_oe_o`, and reads it through `mdio_i`. When the enable is low, an external pull-up holds the line high. Each half of the management clock lasts `HALF_DIV` system cycles. Output data changes only when the management clock falls. Input data is taken in the system cycle in which the management clock rises.

Top module: `mdio_rd_master`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `mdc_o` and `mdio_oe_o` are all 0.
- R2: A frame starts with 32 management clock periods in which the data line is driven to 1.
- R3: After the preamble the block drives the start code 0,1 and then the read opcode 1,0 (frame bits 32 to 35).
- R4: Frame bits 36 to 40 carry the PHY address and bits 41 to 45 carry the register address, each sent most significant bit first.
- R5: From frame bit 46 to the end of the frame, `mdio_oe_o` is 0. This covers the two turnaround bits (46, 47), the data bits and the trailing bits. During bits 0 to 45 it is 1.
- R6: In frame bits 48 to 63 the block samples `mdio_i` at the rising edge of `mdc_o`, most significant bit first. The 16-bit result is on `rdata_o` when `done_o` is high.
- R7: Every frame has exactly 66 rising edges of `mdc_o`. The last two (bits 64, 65) are released idle clocks.
- R8: Each high or low half of `mdc_o` lasts exactly `HALF_DIV` system cycles. A frame begins with `mdc_o` low and the line driven to 1. `mdc_o` stays low while the block is idle.
- R9: `busy_o` goes high in the cycle after an accepted start and stays high until `done_o`. A start pulse that arrives while `busy_o` is high has no effect on the running frame.
- R10: `mdio_o` and `mdio_oe_o` change only at a falling edge of `mdc_o`, or at the start or end of a frame.
- R11: `done_o` is a one-cycle pulse in the cycle in which `busy_o` falls. A start in that same cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | One-cycle request to begin a read frame |
| phy_addr_i | input | 5 | PHY address, taken with the start pulse |
| reg_addr_i | input | 5 | Register address, taken with the start pulse |
| busy_o | output | 1 | High while a frame is in progress |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| rdata_o | output | 16 | Value read from the PHY register |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe_o | output | 1 | Data line driver enable |
| mdio_i | input | 1 | Data line input value |

## Verification
Two events can land in the same cycle: the `done_o` pulse of one frame and the start of the next. The bench launches each new frame in the very cycle in which it sees `done_o`. It then checks that the new frame starts cleanly with 66 clocks and the right header. In the other case, a start pulse with inverted addresses arrives in the middle of a frame. The bench judges it ignored if the captured header and the read value still match the first request and the frame length stays at 66 clocks.

// File: rtl/mdio_rd_pkg.sv
package mdio_rd_pkg;

    localparam int ADDR_W    = 5;
    localparam int HDR_BITS  = 14;
    localparam int TA_BITS   = 2;
    localparam int DATA_BITS = 16;

    typedef struct packed {
        logic [ADDR_W-1:0] phy;
        logic [ADDR_W-1:0] regad;
    } mdio_req_t;

    typedef enum logic [1:0] {
        PH_PRE,
        PH_HDR,
        PH_REL
    } drv_phase_t;

    // start code 01, read opcode 10, then both addresses MSB first
    function automatic logic [HDR_BITS-1:0] build_hdr(input mdio_req_t r);
        return {2'b01, 2'b10, r.phy, r.regad};
    endfunction

endpackage

// File: rtl/mdio_rd_clkgen.sv
module mdio_rd_clkgen #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    output logic mdc_o,
    output logic rise_o,
    output logic fall_o
);
    localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_DIV - 1);

    logic [CNT_W-1:0] cnt;
    logic             mdc;
    logic             wrap;

    assign wrap = run_i && (cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign mdc_o  = mdc;
    assign rise_o = wrap && !mdc;
    assign fall_o = wrap && mdc;

endmodule

// File: rtl/mdio_rd_seq.sv
module mdio_rd_seq
    import mdio_rd_pkg::*;
#(
    parameter int PRE_BITS   = 32,
    parameter int TRAIL_BITS = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      start_i,
    input  mdio_req_t req_i,
    input  logic      rise_i,
    input  logic      fall_i,
    output logic      busy_o,
    output logic      done_o,
    output logic      mdio_o,
    output logic      mdio_oe_o,
    output logic      sample_o
);
    localparam int DRV_BITS = PRE_BITS + HDR_BITS;
    localparam int DATA_LO  = DRV_BITS + TA_BITS;
    localparam int DATA_HI  = DATA_LO + DATA_BITS - 1;
    localparam int LAST_BIT = DATA_HI + TRAIL_BITS;
    localparam int IDX_W    = $clog2(LAST_BIT + 1);

    logic                busy;
    logic                done;
    logic [IDX_W-1:0]    idx;
    logic [HDR_BITS-1:0] hdr;
    drv_phase_t          phase;
    logic [IDX_W-1:0]    hoff;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            idx  <= '0;
            hdr  <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start_i) begin
                    busy <= 1'b1;
                    idx  <= '0;
                    hdr  <= build_hdr(req_i);
                end
            end else if (fall_i) begin
                if (idx == IDX_W'(LAST_BIT)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    always_comb begin
        if (idx < IDX_W'(PRE_BITS))      phase = PH_PRE;
        else if (idx < IDX_W'(DRV_BITS)) phase = PH_HDR;
        else                             phase = PH_REL;
    end

    assign hoff      = IDX_W'(DRV_BITS - 1) - idx;
    assign mdio_o    = (busy && phase == PH_HDR) ? hdr[hoff[3:0]] : 1'b1;
    assign mdio_oe_o = busy && (phase != PH_REL);
    assign sample_o  = busy && rise_i && (idx >= IDX_W'(DATA_LO)) && (idx <= IDX_W'(DATA_HI));
    assign busy_o    = busy;
    assign done_o    = done;

endmodule

// File: rtl/mdio_rd_shift.sv
module mdio_rd_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en_i,
    input  logic         bit_i,
    output logic [W-1:0] data_o
);
    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst)       sr <= '0;
        else if (en_i) sr <= {sr[W-2:0], bit_i};
    end

    assign data_o = sr;

endmodule

// File: rtl/mdio_rd_master.sv
module mdio_rd_master
    import mdio_rd_pkg::*;
#(
    parameter int HALF_DIV   = 4,
    parameter int PRE_BITS   = 32,
    parameter int TRAIL_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic [ADDR_W-1:0]    phy_addr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [DATA_BITS-1:0] rdata_o,
    output logic                 mdc_o,
    output logic                 mdio_o,
    output logic                 mdio_oe_o,
    input  logic                 mdio_i
);
    mdio_req_t req;
    logic      rise, fall, sample, busy;

    assign req.phy   = phy_addr_i;
    assign req.regad = reg_addr_i;

    mdio_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk    (clk),
        .rst    (rst),
        .run_i  (busy),
        .mdc_o  (mdc_o),
        .rise_o (rise),
        .fall_o (fall)
    );

    mdio_rd_seq #(.PRE_BITS(PRE_BITS), .TRAIL_BITS(TRAIL_BITS)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_i   (start_i),
        .req_i     (req),
        .rise_i    (rise),
        .fall_i    (fall),
        .busy_o    (busy),
        .done_o    (done_o),
        .mdio_o    (mdio_o),
        .mdio_oe_o (mdio_oe_o),
        .sample_o  (sample)
    );

    mdio_rd_shift #(.W(DATA_BITS)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en_i   (sample),
        .bit_i  (mdio_i),
        .data_o (rdata_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/mdio_rd_chk.sv
module mdio_rd_chk #(
    parameter int HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic busy_o,
    input logic done_o,
    input logic mdc_o,
    input logic mdio_o,
    input logic mdio_oe_o
);
    logic        mdc_q;
    logic [31:0] hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            mdc_q <= 1'b0;
            hold  <= '0;
        end else begin
            mdc_q <= mdc_o;
            if (!busy_o || mdc_o != mdc_q) hold <= '0;
            else                           hold <= hold + 1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) $fell(rst) |-> !busy_o && !done_o && !mdc_o && !mdio_oe_o); // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) !busy_o |-> !mdc_o && !mdio_oe_o); // R8
    AST_FRAME_OPEN: assert property (@(posedge clk) disable iff (rst) $rose(busy_o) |-> !mdc_o && mdio_oe_o && mdio_o); // R8
    AST_HALF_BOUND: assert property (@(posedge clk) disable iff (rst) busy_o |-> hold <= 32'(HALF_DIV)); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst) done_o |=> !done_o); // R11
    AST_DONE_ENDS: assert property (@(posedge clk) disable iff (rst) $fell(busy_o) |-> done_o); // R11
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done_o |-> !busy_o && !mdio_oe_o); // R9
    AST_DRIVE_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy_o && $past(busy_o) && !$fell(mdc_o)) |-> ($stable(mdio_o) && $stable(mdio_oe_o))); // R10

endmodule

bind mdio_rd_master mdio_rd_chk #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .mdc_o     (mdc_o),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
);

// File: tb/test_mdio_rd_master.sv
`timescale 1ns/1ps
module test_mdio_rd_master;
    localparam int  H     = 4;
    localparam real CLK_P = 8.0;
    localparam int  NBITS = 66;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start_i = 1'b0;
    logic [4:0]  phy_i = '0;
    logic [4:0]  reg_i = '0;
    logic        busy_o, done_o, mdc_o, mdio_o, mdio_oe_o;
    logic [15:0] rdata_o;
    logic        mdio_i = 1'b1;

    int checks = 0;
    int errors = 0;

    bit          cap_d  [0:79];
    bit          cap_oe [0:79];
    int          rise_n = 0;
    logic [15:0] phy_data = '0;
    int          half_bad = 0;
    int          chg_bad = 0;
    realtime     t_last = 0.0;
    bit          last_d = 1'b1, last_oe = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    mdio_rd_master #(.HALF_DIV(H)) i_mdio_rd_master (
        .clk(clk), .rst(rst), .start_i(start_i), .phy_addr_i(phy_i), .reg_addr_i(reg_i),
        .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .mdc_o(mdc_o),
        .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .mdio_i(mdio_i)
    );

    // PHY model: capture master output at rising MDC, present next data bit after it
    always @(posedge mdc_o) begin
        if (rise_n < 80) begin
            cap_d[rise_n]  = mdio_o;
            cap_oe[rise_n] = mdio_oe_o;
        end
        last_d  = mdio_o;
        last_oe = mdio_oe_o;
        if (rise_n + 1 >= 48 && rise_n + 1 <= 63) mdio_i = phy_data[15 - (rise_n + 1 - 48)];
        else                                      mdio_i = 1'b1;
        rise_n = rise_n + 1;
    end

    always @(posedge busy_o) t_last = $realtime;
    always @(mdc_o) begin
        if ($realtime - t_last != H * CLK_P) half_bad = half_bad + 1;
        t_last = $realtime;
    end

    always @(negedge clk) begin
        if (busy_o && mdc_o && (mdio_o != last_d || mdio_oe_o != last_oe)) chg_bad = chg_bad + 1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic bit exp_bit(input logic [4:0] p, input logic [4:0] r, input int i);
        logic [13:0] h;
        h = {2'b01, 2'b10, p, r};
        if (i < 32) return 1'b1;
        if (i < 46) return h[13 - (i - 32)];
        return 1'b1;
    endfunction

    task automatic frame(input logic [4:0] p, input logic [4:0] r, input logic [15:0] d, input bit poke);
        int n;
        int bad_pre, bad_op, bad_adr, bad_oe;
        phy_data = d;
        rise_n = 0; half_bad = 0; chg_bad = 0;
        phy_i = p; reg_i = r; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o == 1'b1 && done_o == 1'b0, "R9 busy after start", {busy_o, done_o}, 2);
        if (poke) begin
            repeat (150) @(negedge clk);
            phy_i = ~p; reg_i = ~r; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            check(busy_o == 1'b1, "R9 busy through ignored start", busy_o, 1);
        end
        n = 0;
        while (!done_o && n < 4000) begin
            @(negedge clk);
            n = n + 1;
        end
        check(done_o == 1'b1, "R11 done seen", done_o, 1);
        check(busy_o == 1'b0, "R11 busy low with done", busy_o, 0);
        bad_pre = 0; bad_op = 0; bad_adr = 0; bad_oe = 0;
        for (int i = 0; i < NBITS; i++) begin
            if (i < 32 && cap_d[i] != 1'b1) bad_pre++;
            if (i >= 32 && i < 36 && cap_d[i] != exp_bit(p, r, i)) bad_op++;
            if (i >= 36 && i < 46 && cap_d[i] != exp_bit(p, r, i)) bad_adr++;
            if (cap_oe[i] != (i < 46)) bad_oe++;
        end
        check(bad_pre == 0, "R2 preamble ones", bad_pre, 0);
        check(bad_op == 0, "R3 start and read codes", bad_op, 0);
        check(bad_adr == 0, poke ? "R9 R4 addresses kept" : "R4 addresses", bad_adr, 0);
        check(bad_oe == 0, "R5 release pattern", bad_oe, 0);
        check(rdata_o == d, "R6 read data", rdata_o, d);
        check(rise_n == NBITS, "R7 rising edges", rise_n, NBITS);
        check(half_bad == 0, "R8 half period", half_bad, 0);
        check(chg_bad == 0, "R10 output changes only on fall", chg_bad, 0);
    endtask

    initial begin
        #(200000 * CLK_P);
        errors = errors + 1;
        $display("FAIL watchdog actual %0d expected %0d", 0, 1);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy_o && !done_o && !mdc_o && !mdio_oe_o, "R1 reset state",
              {busy_o, done_o, mdc_o, mdio_oe_o}, 0);
        repeat (3) @(negedge clk);
        check(!mdc_o && !mdio_oe_o, "R8 idle clock low", {mdc_o, mdio_oe_o}, 0);
        // directed corners; every call starts in the cycle done is seen (R11 back-to-back)
        frame(5'd0, 5'd0, 16'h0000, 1'b0);
        frame(5'd31, 5'd31, 16'hFFFF, 1'b0);
        frame(5'd1, 5'd17, 16'h8001, 1'b0);
        frame(5'd5, 5'd9, 16'hA55A, 1'b1);
        repeat (7) @(negedge clk);
        for (int k = 0; k < 20; k++) begin
            frame(5'($urandom), 5'($urandom), 16'($urandom), ($urandom % 4) == 0);
            if (($urandom % 2) == 0) repeat (1 + $urandom % 9) @(negedge clk);
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule